// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital heart of a differential successive-approximation converter. A host drives an active-low chip select and a serial clock. The block answers with a serial data line and an enable for it. Around it sit a sample/hold switch, a binary-weighted DAC and a comparator, and the block steers all three: it drives the hold control and the DAC trial code, and it reads back one comparator decision per bit.

Both host signals arrive already synchronised to the local clock `clk`. The block acts on their edges, so the whole conversion is paced by the host's serial clock. Each result bit goes out on the data line in the same serial cycle in which it is decided.

Chip select alone picks between active and low-power operation. Raising it ends a frame at any point. The first frame after reset only primes the track/hold, so its data is never driven. The only data path is the serial line. It has no flow control: the host's clock sets the pace, and a bit the host fails to capture is gone.

Top module: `sar_conv_seq`

## Requirements
- R1: When chip select falls while the block is idle, a frame starts. `track_o` stays 1 until the third serial-clock falling edge of the frame, and goes to 0 (hold) in the `clk` cycle after that edge is detected.
- R2: The first trial code shown on `dac_code_o` is 0 (two's-complement midscale). Each later serial falling edge reads `cmp_i`, where 1 means the held input is at or above the trial code. It fixes the current bit and moves the trial by half the previous step. After the last decision, `dac_code_o` equals the signed result and `track_o` returns to 1.
- R3: With 12 result bits, the data line shows a frame of 16 slots. Slot 0 appears when chip select falls, and slot k appears after falling edge k. Slots 0 to 3 are 0, and slots 4 to 15 carry the two's-complement result from bit 11 down to bit 0. After falling edge 16, `sdo_en_o` drops to 0.
- R4: While `sdo_en_o` stays 1, `sdo_o` changes only in the `clk` cycle after a serial falling edge is detected.
- R5: If chip select is sampled high in any state, then on the next `clk` cycle `sdo_en_o` is 0, `track_o` is 1 and `dac_code_o` is 0. No minimum number of serial cycles applies.
- R6: `mode_dyn_o` is 1 one `clk` cycle after chip select is sampled low, and 0 one cycle after it is sampled high.
- R7: After reset, `init_done_o` is 0 and `sdo_en_o` stays 0 throughout the first frame. `init_done_o` becomes 1 when that frame ends, either at falling edge 16 or by chip select rising, and then stays 1.
- R8: With `RES_BITS` = 10, slots 4 to 13 carry result bits 9 down to 0. Slots 14 and 15 are 0, and the frame still ends at falling edge 16.
- R9: After a frame ends while chip select stays low, further serial edges change nothing. A new frame needs chip select to go high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the host signals |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sclk_i | input | 1 | Host serial clock, synchronised; idles high |
| cs_n_i | input | 1 | Host chip select, active low, synchronised |
| cmp_i | input | 1 | Comparator decision: 1 when held input >= trial code |
| track_o | output | 1 | 1 = track the input, 0 = hold it |
| dac_code_o | output | RES_BITS | Signed trial code for the DAC |
| sdo_o | output | 1 | Serial data bit |
| sdo_en_o | output | 1 | Output enable for the data line; 0 means tri-state |
| mode_dyn_o | output | 1 | 1 = dynamic (active), 0 = static low-power |
| init_done_o | output | 1 | Set once the priming frame after reset has ended |

## Verification
The bench goes after the frame boundaries, since these are where an off-by-one shows up most easily.

- **Hold and first decision.** A design that holds one edge too soon or too late shifts every bit by one slot, so the serial word captured by the host no longer matches.
- **Extreme codes and the sign bit.** Full-scale positive, full-scale negative, zero and minus one exercise the inverted sign bit. A converter that kept offset-binary coding would output the wrong sign.
- **Aborts.** Chip select is raised before any serial edge, inside acquisition and in mid-conversion. A design that ignored the abort would keep driving the line or leave the DAC off midscale.
- **Extra edges after a frame.** These catch a design that restarts without a fresh chip-select fall.
- **Priming frame.** Both a completed and an aborted priming frame are run, to catch data leaking out while `init_done_o` is low.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_TAIL,
    ST_DONE
  } seq_state_t;

  localparam int FRAME_EDGES = 16;
  localparam int ACQ_EDGES   = 3;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  output logic sclk_fall_o,
  output logic cs_fall_o
);

  logic sclk_q;
  logic cs_q;

  // Both host lines idle high, so reset to high to avoid a phantom edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_n_i;
    end
  end

  assign sclk_fall_o = sclk_q & ~sclk_i;
  assign cs_fall_o   = cs_q & ~cs_n_i;

endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int FRAME_N  = FRAME_EDGES,
  parameter int ACQ_N    = ACQ_EDGES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n_i,
  input  logic                        sclk_fall_i,
  input  logic                        cs_fall_i,
  output logic                        track_o,
  output logic                        sdo_en_o,
  output logic                        mode_dyn_o,
  output logic                        init_done_o,
  output logic                        load_mid_o,
  output logic                        decide_o,
  output logic                        zero_o,
  output logic [$clog2(RES_BITS)-1:0] bit_idx_o
);

  localparam int CW = $clog2(FRAME_N + 1);
  localparam int BW = $clog2(RES_BITS);
  localparam logic [CW-1:0] ACQ_LAST   = CW'(ACQ_N);
  localparam logic [CW-1:0] FRAME_LAST = CW'(FRAME_N);
  localparam logic [BW-1:0] TOP_BIT    = BW'(RES_BITS - 1);

  seq_state_t     state_q;
  logic [CW-1:0]  edge_q;
  logic [CW-1:0]  edge_nx;
  logic [BW-1:0]  bidx_q;
  logic           track_q;
  logic           en_q;
  logic           init_q;
  logic           mode_q;
  logic           start;

  assign edge_nx = edge_q + CW'(1);
  assign start   = (state_q == ST_IDLE) && cs_fall_i;

  // Strobes to the datapath: reload midscale, latch a decision, or force a zero slot.
  always_comb begin
    load_mid_o = 1'b0;
    decide_o   = 1'b0;
    zero_o     = 1'b0;
    if (cs_n_i) begin
      load_mid_o = 1'b1;
    end else if (start) begin
      load_mid_o = 1'b1;
      zero_o     = 1'b1;
    end else if (sclk_fall_i) begin
      unique case (state_q)
        ST_ACQ: begin
          zero_o = 1'b1;
          if (edge_nx == ACQ_LAST) load_mid_o = 1'b1;
        end
        ST_CONV: decide_o = 1'b1;
        ST_TAIL: zero_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      bidx_q  <= TOP_BIT;
      track_q <= 1'b1;
      en_q    <= 1'b0;
      init_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= ~cs_n_i;
      if (cs_n_i) begin
        // Abort or static: no minimum serial-cycle count applies.
        state_q <= ST_IDLE;
        edge_q  <= '0;
        track_q <= 1'b1;
        en_q    <= 1'b0;
        if (state_q != ST_IDLE) init_q <= 1'b1;
      end else if (start) begin
        state_q <= ST_ACQ;
        edge_q  <= '0;
        track_q <= 1'b1;
        en_q    <= init_q;
      end else if (sclk_fall_i) begin
        unique case (state_q)
          ST_ACQ: begin
            edge_q <= edge_nx;
            if (edge_nx == ACQ_LAST) begin
              state_q <= ST_CONV;
              track_q <= 1'b0;
              bidx_q  <= TOP_BIT;
            end
          end
          ST_CONV: begin
            edge_q <= edge_nx;
            if (bidx_q == '0) begin
              state_q <= ST_TAIL;
              track_q <= 1'b1;
            end else begin
              bidx_q <= bidx_q - BW'(1);
            end
          end
          ST_TAIL: begin
            edge_q <= edge_nx;
            if (edge_nx == FRAME_LAST) begin
              state_q <= ST_DONE;
              en_q    <= 1'b0;
              init_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign track_o     = track_q;
  assign sdo_en_o    = en_q;
  assign mode_dyn_o  = mode_q;
  assign init_done_o = init_q;
  assign bit_idx_o   = bidx_q;

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_mid_i,
  input  logic                        decide_i,
  input  logic [$clog2(RES_BITS)-1:0] bit_idx_i,
  input  logic                        cmp_i,
  output logic [RES_BITS-1:0]         dac_code_o,
  output logic                        dec_bit_o
);

  localparam int BW = $clog2(RES_BITS);
  localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

  // Offset-binary working register; the DAC sees it with the sign bit flipped.
  logic [RES_BITS-1:0] ob_q;
  logic [RES_BITS-1:0] ob_nx;

  for (genvar k = 0; k < RES_BITS; k++) begin : g_bit
    if (k < RES_BITS - 1) begin : g_low
      assign ob_nx[k] = load_mid_i                              ? MID[k] :
                        (decide_i && bit_idx_i == BW'(k))       ? cmp_i  :
                        (decide_i && bit_idx_i == BW'(k + 1))   ? 1'b1   :
                        ob_q[k];
    end else begin : g_top
      assign ob_nx[k] = load_mid_i                              ? MID[k] :
                        (decide_i && bit_idx_i == BW'(k))       ? cmp_i  :
                        ob_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ob_q <= MID;
    else        ob_q <= ob_nx;
  end

  assign dac_code_o = ob_q ^ MID;
  assign dec_bit_o  = (bit_idx_i == BW'(RES_BITS - 1)) ? ~cmp_i : cmp_i;

endmodule

// File: rtl/sar_sdo_drv.sv
module sar_sdo_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_i,
  input  logic decide_i,
  input  logic dec_bit_i,
  output logic sdo_o
);

  logic sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (zero_i)   sdo_q <= 1'b0;
    else if (decide_i) sdo_q <= dec_bit_i;
  end

  assign sdo_o = sdo_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_i,
  input  logic                cs_n_i,
  input  logic                cmp_i,
  output logic                track_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                sdo_o,
  output logic                sdo_en_o,
  output logic                mode_dyn_o,
  output logic                init_done_o
);

  localparam int BW = $clog2(RES_BITS);

  logic          sclk_fall;
  logic          cs_fall;
  logic          load_mid;
  logic          decide;
  logic          zero;
  logic [BW-1:0] bit_idx;
  logic          dec_bit;

  sar_edge_det u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk_i),
    .cs_n_i      (cs_n_i),
    .sclk_fall_o (sclk_fall),
    .cs_fall_o   (cs_fall)
  );

  sar_frame_ctl #(
    .RES_BITS (RES_BITS),
    .FRAME_N  (FRAME_EDGES),
    .ACQ_N    (ACQ_EDGES)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .sclk_fall_i (sclk_fall),
    .cs_fall_i   (cs_fall),
    .track_o     (track_o),
    .sdo_en_o    (sdo_en_o),
    .mode_dyn_o  (mode_dyn_o),
    .init_done_o (init_done_o),
    .load_mid_o  (load_mid),
    .decide_o    (decide),
    .zero_o      (zero),
    .bit_idx_o   (bit_idx)
  );

  sar_approx_reg #(
    .RES_BITS (RES_BITS)
  ) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_mid_i (load_mid),
    .decide_i   (decide),
    .bit_idx_i  (bit_idx),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .dec_bit_o  (dec_bit)
  );

  sar_sdo_drv u_sdo (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_i    (zero),
    .decide_i  (decide),
    .dec_bit_i (dec_bit),
    .sdo_o     (sdo_o)
  );

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n_i,
  input logic                sclk_fall,
  input logic                track_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic                sdo_o,
  input logic                sdo_en_o,
  input logic                mode_dyn_o,
  input logic                init_done_o
);

  AST_HOLD_ON_SCLK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_o) |-> $past(sclk_fall)); // R1

  AST_FIRST_TRIAL_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track_o) |-> (dac_code_o == '0)); // R2

  AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en_o && $past(sdo_en_o) && (sdo_o != $past(sdo_o))) |-> $past(sclk_fall)); // R4

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i) |-> (!sdo_en_o && track_o && dac_code_o == '0)); // R5

  AST_STATIC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i) |-> !mode_dyn_o); // R6

  AST_DYNAMIC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_n_i) |-> mode_dyn_o); // R6

  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> !sdo_en_o); // R7

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_done_o) |-> init_done_o); // R7

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n_i      (cs_n_i),
  .sclk_fall   (sclk_fall),
  .track_o     (track_o),
  .dac_code_o  (dac_code_o),
  .sdo_o       (sdo_o),
  .sdo_en_o    (sdo_en_o),
  .mode_dyn_o  (mode_dyn_o),
  .init_done_o (init_done_o)
);

// File: tb/tb_sar_conv_seq.sv
module tb_sar_model #(
  parameter int N = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  int   x,
  output logic e_track,
  output logic e_en,
  output logic e_sdo,
  output logic e_mode,
  output logic e_init,
  output int   e_dac
);

  bit   q[$];
  int   edges;
  bit   active;
  logic sclk_p;
  logic cs_p;

  // Trial code for bit k, given that every higher bit already matches the input.
  function automatic int trial(input int v, input int k);
    int half;
    int xo;
    half = 1 << (N - 1);
    xo   = v + half;
    return (((xo >> (k + 1)) << (k + 1)) | (1 << k)) - half;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p = 1'b1; cs_p = 1'b1;
      e_track = 1'b1; e_en = 1'b0; e_sdo = 1'b0; e_mode = 1'b0;
      e_init = 1'b0; e_dac = 0; active = 1'b0; edges = 0;
      q.delete();
    end else begin
      bit sf;
      bit cf;
      int k;
      sf = sclk_p && !sclk;
      cf = cs_p && !cs_n;
      sclk_p = sclk;
      cs_p = cs_n;
      e_mode = !cs_n;
      if (cs_n) begin
        if (active) e_init = 1'b1;
        active = 1'b0; e_en = 1'b0; e_track = 1'b1; e_dac = 0;
      end else if (!active && cf) begin
        active = 1'b1; edges = 0; q.delete();
        for (int s = 0; s < 16; s++) begin
          if (s >= 4 && s < 4 + N) q.push_back(bit'((x >> (N - 1 - (s - 4))) & 1));
          else q.push_back(1'b0);
        end
        e_sdo = q.pop_front();
        e_en = e_init; e_track = 1'b1; e_dac = 0;
      end else if (active && sf) begin
        edges++;
        if (edges == 3) begin
          e_track = 1'b0;
          e_dac = trial(x, N - 1);
        end
        if (edges >= 4 && edges <= N + 3) begin
          k = N + 3 - edges;
          if (k > 0) e_dac = trial(x, k - 1);
          else begin e_dac = x; e_track = 1'b1; end
        end
        if (edges < 16) e_sdo = q.pop_front();
        else begin e_en = 1'b0; active = 1'b0; e_init = 1'b1; end
      end
    end
  end

endmodule

module tb_sar_conv_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  int   x12 = 0;
  int   x10 = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  logic        cmp12, track12, sdo12, en12, mode12, init12;
  logic [11:0] dac12;
  logic        cmp10, track10, sdo10, en10, mode10, init10;
  logic [9:0]  dac10;

  assign cmp12 = (x12 >= int'($signed(dac12)));
  assign cmp10 = (x10 >= int'($signed(dac10)));

  sar_conv_seq #(.RES_BITS(12)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .cmp_i(cmp12),
    .track_o(track12), .dac_code_o(dac12), .sdo_o(sdo12), .sdo_en_o(en12),
    .mode_dyn_o(mode12), .init_done_o(init12)
  );

  sar_conv_seq #(.RES_BITS(10)) dut_n10 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .cmp_i(cmp10),
    .track_o(track10), .dac_code_o(dac10), .sdo_o(sdo10), .sdo_en_o(en10),
    .mode_dyn_o(mode10), .init_done_o(init10)
  );

  logic m12_track, m12_en, m12_sdo, m12_mode, m12_init;
  int   m12_dac;
  logic m10_track, m10_en, m10_sdo, m10_mode, m10_init;
  int   m10_dac;

  tb_sar_model #(.N(12)) ref12 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .x(x12),
    .e_track(m12_track), .e_en(m12_en), .e_sdo(m12_sdo), .e_mode(m12_mode),
    .e_init(m12_init), .e_dac(m12_dac)
  );

  tb_sar_model #(.N(10)) ref10 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .x(x10),
    .e_track(m10_track), .e_en(m10_en), .e_sdo(m10_sdo), .e_mode(m10_mode),
    .e_init(m10_init), .e_dac(m10_dac)
  );

  task automatic check_val(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Cycle-by-cycle comparison against the reference models, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R1", "track12", int'(track12), int'(m12_track));
      check_val("R2", "dac12", int'($signed(dac12)), m12_dac);
      check_val("R3/R5", "sdo_en12", int'(en12), int'(m12_en));
      if (m12_en) check_val("R3/R4", "sdo12", int'(sdo12), int'(m12_sdo));
      check_val("R6", "mode12", int'(mode12), int'(m12_mode));
      check_val("R7", "init12", int'(init12), int'(m12_init));
      check_val("R8", "track10", int'(track10), int'(m10_track));
      check_val("R8", "dac10", int'($signed(dac10)), m10_dac);
      check_val("R8", "sdo_en10", int'(en10), int'(m10_en));
      if (m10_en) check_val("R8", "sdo10", int'(sdo10), int'(m10_sdo));
    end
  end

  task automatic frame(input int a, input int b, input int ncyc, input bit word_chk);
    logic [15:0] w12;
    logic [15:0] w10;
    logic [15:0] e12;
    logic [15:0] e10;
    w12 = '0; w10 = '0;
    x12 = a; x10 = b;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < ncyc; i++) begin
      if (i < 16) begin
        w12 = {w12[14:0], sdo12};
        w10 = {w10[14:0], sdo10};
      end
      sclk = 1'b0;
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
    end
    if (word_chk) begin
      e12 = {4'b0000, a[11:0]};
      e10 = {4'b0000, b[9:0], 2'b00};
      check_val("R3", "word12", int'(w12), int'(e12));
      check_val("R8", "word10", int'(w10), int'(e10));
      check_val("R3", "en12 after 16 edges", int'(en12), 0);
    end
    if (ncyc > 16) begin
      check_val("R9", "en12 after extra edges", int'(en12), 0);
      check_val("R9", "track12 after extra edges", int'(track12), 1);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    int seed;
    int ra;
    int rb;
    seed = 7;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R7", "init after reset", int'(init12), 0);
    check_val("R1", "track after reset", int'(track12), 1);
    check_val("R6", "mode after reset", int'(mode12), 0);
    check_val("R5", "en after reset", int'(en12), 0);

    // Priming frame: data line must stay released.
    frame(100, 50, 16, 1'b0);
    check_val("R7", "init after dummy", int'(init12), 1);

    frame(2047, 511, 16, 1'b1);
    frame(-2048, -512, 16, 1'b1);
    frame(0, 0, 16, 1'b1);
    frame(-1, -1, 16, 1'b1);
    frame(1365, 300, 16, 1'b1);
    frame(-683, -200, 16, 1'b1);

    // Aborts before any edge, inside acquisition and mid-conversion.
    frame(500, 100, 0, 1'b0);
    frame(500, 100, 2, 1'b0);
    frame(-900, -300, 8, 1'b0);
    frame(777, 222, 16, 1'b1);

    // Extra serial edges after the frame end.
    frame(-1234, 123, 21, 1'b1);

    for (int i = 0; i < 10; i++) begin
      seed = seed * 1103515245 + 12345;
      ra = ((seed >> 4) & 32'hFFF) - 2048;
      rb = ((seed >> 16) & 32'h3FF) - 512;
      frame(ra, rb, 16, 1'b1);
    end

    // Second reset: the priming frame is aborted this time.
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R7", "init after second reset", int'(init12), 0);
    frame(42, 21, 5, 1'b0);
    check_val("R7", "init after aborted dummy", int'(init12), 1);
    frame(1000, -400, 16, 1'b1);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule